// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block steps a low-power radio chip through its six operating modes (Reset, Standby, Sleep, Active, Receive and Transmit) and drives one enable line per power or clock domain. It takes an external reset, a wake-timer expiry, a wake request from the serial host port and software requests. It then picks the next mode and holds the transition open for a settling time, counted in system clock cycles, before it reports the new mode as reached.

Every settling time is a parameter. The integrator converts the required microsecond figures into cycles of the system clock. The wake-up times from Reset and from Standby depend on the low-speed clock source that is fitted. The time to enter Receive or Transmit from Active depends on whether a channel change is asked for with the request. A separate output tells the clock multiplexer when the high-speed crystal may take over from the fast ring oscillator.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `ext_reset_i` is high, each clock edge puts the block in Reset (`mode_o` = 0), clears `busy_o` and drives every domain enable low. A transition that is in progress is aborted.
- R2: In Reset with `ext_reset_i` low, the block starts the wake-up to Active (`mode_o` = 3). `mode_o` reaches Active exactly D cycles after the starting edge. D is `D_RST_NOLS`, `D_RST_RING` or `D_RST_XTAL` when `ls_src_i` is 00, 01 or 1x (no low-speed clock, ring oscillator, crystal).
- R3: `dom_en_o` bit positions are: 0 regulator, 1 serial port, 2 low-speed oscillator, 3 high-speed oscillator, 4 core, 5 synthesizer, 6 receive chain, 7 transmit chain, 8 secondary RAM bank. The set per mode is:
  - Reset: none.
  - Standby: 0, 1, 8.
  - Sleep: 0, 1, 2, 8.
  - Active: 0 through 4, plus 8.
  - Receive (`mode_o` = 4): the Active set plus 5 and 6.
  - Transmit (`mode_o` = 5): the Active set plus 5 and 7.
- R4: The receive and transmit chain enables are never high together. A switch between Receive and Transmit takes `D_RADIO_SWAP` cycles.
- R5: The time to go from Active to Receive is `D_RX_CHG` when `chan_change_i` is high with the request and `D_RX_SAME` when it is low. The time to go from Active to Transmit is `D_TX_CHG` or `D_TX_SAME` under the same rule.
- R6: Sleep (`mode_o` = 2) leaves for Active on `wake_timer_i` or on `spi_wake_i`. The move takes `D_SLP_WAKE` cycles.
- R7: Standby (`mode_o` = 1) ignores `wake_timer_i` and software requests. It leaves for Active only on `spi_wake_i`. The move takes `D_SBY_NOLS`, `D_SBY_RING` or `D_SBY_XTAL` cycles, chosen by `ls_src_i` as in R2.
- R8: `busy_o` is high for exactly the D cycles of a transition. During that time `mode_o` keeps the old mode, and any request that arrives is dropped rather than queued.
- R9: In Active the requests rank standby, then sleep, then receive, then transmit. Entering Standby or Sleep takes `D_ENTER_LOW` cycles. In Receive, a transmit request outranks `req_active_i`. In Transmit, a receive request outranks `req_active_i`. Leaving either radio mode for Active takes `D_ENTER_LOW` cycles.
- R10: With `ram_off_i` high, enable bit 8 is low in Standby and Sleep. The bit is unaffected in Active, Receive and Transmit.
- R11: `clk_xtal_o` rises on the edge after `xtal_ready_i` is seen high while enable bit 3 is high. It falls on the edge after bit 3 goes low.
- R12: `dom_en_o` takes the target mode's set at the edge that starts a transition, while `mode_o` still shows the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_reset_i | input | 1 | External reset, active high |
| wake_timer_i | input | 1 | Internal wake timer expired |
| spi_wake_i | input | 1 | Wake request from the serial host port |
| req_standby_i | input | 1 | Software request: Standby |
| req_sleep_i | input | 1 | Software request: Sleep |
| req_rx_i | input | 1 | Software request: Receive |
| req_tx_i | input | 1 | Software request: Transmit |
| req_active_i | input | 1 | Software request: return to Active from a radio mode |
| chan_change_i | input | 1 | A channel change goes with the radio request |
| ls_src_i | input | 2 | Low-speed clock source: 00 none, 01 ring, 1x crystal |
| ram_off_i | input | 1 | Power the secondary RAM bank down in Standby and Sleep |
| xtal_ready_i | input | 1 | High-speed crystal has settled |
| mode_o | output | 3 | Reached mode: 0 Reset, 1 Standby, 2 Sleep, 3 Active, 4 Receive, 5 Transmit |
| busy_o | output | 1 | A transition is in progress |
| dom_en_o | output | 9 | Domain enables, bit positions as in R3 |
| clk_xtal_o | output | 1 | Core clock may run from the crystal |

## Verification
The assertions check the following on every cycle:
- External reset clears the block on the next edge.
- The two radio chains are never enabled together.
- The regulator is on in every mode except Reset.
- `mode_o` changes only on the edge where `busy_o` falls.
- The settle counter steps down by one each cycle.
- The transition target stays fixed while busy.
- Standby ignores everything but the serial wake, and Sleep wakes on either source.
- The crystal select follows the oscillator enable.

Only the bench scenarios can show the following:
- Each transition lasts exactly its parameterised number of cycles for each clock source and channel-change setting.
- The request priority works when requests arrive together.
- The RAM-bank option and the per-mode enable sets match the mode table.

// File: rtl/pwr_seq_pkg.sv
// Shared types for the power mode sequencer.
// Assumes: the mode codes are seen by software and the bench, so they stay fixed.
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        PM_RESET   = 3'd0,
        PM_STANDBY = 3'd1,
        PM_SLEEP   = 3'd2,
        PM_ACTIVE  = 3'd3,
        PM_RX      = 3'd4,
        PM_TX      = 3'd5
    } pm_mode_e;

    // Domain enable bit positions
    localparam int DOM_N    = 9;
    localparam int DOM_REG  = 0;
    localparam int DOM_SPI  = 1;
    localparam int DOM_LSO  = 2;
    localparam int DOM_HSO  = 3;
    localparam int DOM_CORE = 4;
    localparam int DOM_SYN  = 5;
    localparam int DOM_RXC  = 6;
    localparam int DOM_TXC  = 7;
    localparam int DOM_RAMB = 8;

    // Larger of two delay values, used to size the settle counter
    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pms_req_decode.sv
// Decides whether a transition starts this cycle, and picks its target and length.
// Assumes: idle_i is low while busy or in external reset. All delays are at least 1.
module pms_req_decode
    import pwr_seq_pkg::*;
#(
    parameter int unsigned D_RST_NOLS   = 1500,
    parameter int unsigned D_RST_RING   = 7000,
    parameter int unsigned D_RST_XTAL   = 94000,
    parameter int unsigned D_SBY_NOLS   = 420,
    parameter int unsigned D_SBY_RING   = 6200,
    parameter int unsigned D_SBY_XTAL   = 93000,
    parameter int unsigned D_SLP_WAKE   = 420,
    parameter int unsigned D_RX_CHG     = 125,
    parameter int unsigned D_RX_SAME    = 61,
    parameter int unsigned D_TX_CHG     = 131,
    parameter int unsigned D_TX_SAME    = 67,
    parameter int unsigned D_RADIO_SWAP = 150,
    parameter int unsigned D_ENTER_LOW  = 2,
    parameter int          CNT_W        = 17
) (
    input  pm_mode_e           mode_i,
    input  logic               idle_i,
    input  logic               wake_timer_i,
    input  logic               spi_wake_i,
    input  logic               req_standby_i,
    input  logic               req_sleep_i,
    input  logic               req_rx_i,
    input  logic               req_tx_i,
    input  logic               req_active_i,
    input  logic               chan_change_i,
    input  logic [1:0]         ls_src_i,
    output logic               start_o,
    output pm_mode_e           tgt_o,
    output logic [CNT_W-1:0]   len_o
);

    localparam logic [CNT_W-1:0] L_RST_NOLS = CNT_W'(D_RST_NOLS);
    localparam logic [CNT_W-1:0] L_RST_RING = CNT_W'(D_RST_RING);
    localparam logic [CNT_W-1:0] L_RST_XTAL = CNT_W'(D_RST_XTAL);
    localparam logic [CNT_W-1:0] L_SBY_NOLS = CNT_W'(D_SBY_NOLS);
    localparam logic [CNT_W-1:0] L_SBY_RING = CNT_W'(D_SBY_RING);
    localparam logic [CNT_W-1:0] L_SBY_XTAL = CNT_W'(D_SBY_XTAL);
    localparam logic [CNT_W-1:0] L_SLP      = CNT_W'(D_SLP_WAKE);
    localparam logic [CNT_W-1:0] L_RX_CHG   = CNT_W'(D_RX_CHG);
    localparam logic [CNT_W-1:0] L_RX_SAME  = CNT_W'(D_RX_SAME);
    localparam logic [CNT_W-1:0] L_TX_CHG   = CNT_W'(D_TX_CHG);
    localparam logic [CNT_W-1:0] L_TX_SAME  = CNT_W'(D_TX_SAME);
    localparam logic [CNT_W-1:0] L_SWAP     = CNT_W'(D_RADIO_SWAP);
    localparam logic [CNT_W-1:0] L_LOW      = CNT_W'(D_ENTER_LOW);

    logic [CNT_W-1:0] rst_len;
    logic [CNT_W-1:0] sby_len;

    // Wake-up lengths chosen by the low-speed clock source
    always_comb begin
        case (ls_src_i)
            2'b00:   begin rst_len = L_RST_NOLS; sby_len = L_SBY_NOLS; end
            2'b01:   begin rst_len = L_RST_RING; sby_len = L_SBY_RING; end
            default: begin rst_len = L_RST_XTAL; sby_len = L_SBY_XTAL; end
        endcase
    end

    // Per-mode wake rules and request priority
    always_comb begin
        start_o = 1'b0;
        tgt_o   = mode_i;
        len_o   = L_LOW;
        if (idle_i) begin
            case (mode_i)
                PM_RESET: begin
                    start_o = 1'b1; tgt_o = PM_ACTIVE; len_o = rst_len;
                end
                PM_STANDBY: begin
                    if (spi_wake_i) begin
                        start_o = 1'b1; tgt_o = PM_ACTIVE; len_o = sby_len;
                    end
                end
                PM_SLEEP: begin
                    if (wake_timer_i || spi_wake_i) begin
                        start_o = 1'b1; tgt_o = PM_ACTIVE; len_o = L_SLP;
                    end
                end
                PM_ACTIVE: begin
                    if (req_standby_i) begin
                        start_o = 1'b1; tgt_o = PM_STANDBY; len_o = L_LOW;
                    end else if (req_sleep_i) begin
                        start_o = 1'b1; tgt_o = PM_SLEEP; len_o = L_LOW;
                    end else if (req_rx_i) begin
                        start_o = 1'b1; tgt_o = PM_RX;
                        len_o   = chan_change_i ? L_RX_CHG : L_RX_SAME;
                    end else if (req_tx_i) begin
                        start_o = 1'b1; tgt_o = PM_TX;
                        len_o   = chan_change_i ? L_TX_CHG : L_TX_SAME;
                    end
                end
                PM_RX: begin
                    if (req_tx_i) begin
                        start_o = 1'b1; tgt_o = PM_TX; len_o = L_SWAP;
                    end else if (req_active_i) begin
                        start_o = 1'b1; tgt_o = PM_ACTIVE; len_o = L_LOW;
                    end
                end
                PM_TX: begin
                    if (req_rx_i) begin
                        start_o = 1'b1; tgt_o = PM_RX; len_o = L_SWAP;
                    end else if (req_active_i) begin
                        start_o = 1'b1; tgt_o = PM_ACTIVE; len_o = L_LOW;
                    end
                end
                default: begin
                    start_o = 1'b1; tgt_o = PM_ACTIVE; len_o = rst_len;
                end
            endcase
        end
    end

endmodule

// File: rtl/pms_settle_timer.sv
// Down-counter that holds a transition open for a given number of cycles.
// Assumes: len_i >= 1. start_i only arrives while the timer is not running.
module pms_settle_timer #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             running_o,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Load, count down, and stop after the last cycle
    always_ff @(posedge clk) begin
        if (!rst_n || abort_i) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= len_i - CNT_W'(1);
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign running_o = run_q;
    assign done_o    = run_q && (cnt_q == '0);

    // R8: while running and not yet at zero, the count drops by exactly one
    a_r8_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != '0 && !abort_i) |=> (run_q && cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R8: a finished count always releases the timer
    a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !run_q);

endmodule

// File: rtl/pms_domain_map.sv
// Maps a mode to the set of domain enables (see R3), with the RAM-bank option.
// Assumes: the caller passes the target mode while a transition is in progress.
module pms_domain_map
    import pwr_seq_pkg::*;
(
    input  pm_mode_e         mode_i,
    input  logic             ram_off_i,
    output logic [DOM_N-1:0] en_o
);

    logic low_power;

    // The RAM-bank option applies only in Standby and Sleep
    assign low_power = (mode_i == PM_STANDBY) || (mode_i == PM_SLEEP);

    // Build the enable set level by level
    always_comb begin
        en_o = '0;
        if (mode_i != PM_RESET) begin
            en_o[DOM_REG]  = 1'b1;
            en_o[DOM_SPI]  = 1'b1;
            en_o[DOM_RAMB] = !(low_power && ram_off_i);
        end
        if (mode_i == PM_SLEEP || mode_i == PM_ACTIVE || mode_i == PM_RX || mode_i == PM_TX) begin
            en_o[DOM_LSO] = 1'b1;
        end
        if (mode_i == PM_ACTIVE || mode_i == PM_RX || mode_i == PM_TX) begin
            en_o[DOM_HSO]  = 1'b1;
            en_o[DOM_CORE] = 1'b1;
        end
        if (mode_i == PM_RX || mode_i == PM_TX) begin
            en_o[DOM_SYN] = 1'b1;
        end
        en_o[DOM_RXC] = (mode_i == PM_RX);
        en_o[DOM_TXC] = (mode_i == PM_TX);
    end

endmodule

// File: rtl/pms_clk_switch.sv
// Chooses the core clock: the fast ring oscillator until the crystal reports ready.
// Assumes: xtal_ready_i is already synchronised to clk.
module pms_clk_switch (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_en_i,
    input  logic xtal_ready_i,
    output logic use_xtal_o
);

    logic sel_q;

    // Latch readiness while the oscillator is powered, and drop it when power goes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (!hs_en_i) begin
            sel_q <= 1'b0;
        end else if (xtal_ready_i) begin
            sel_q <= 1'b1;
        end
    end

    assign use_xtal_o = sel_q;

    // R11: the select drops one edge after the oscillator loses its enable
    a_r11_drop_with_osc: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_en_i |=> !sel_q);

    // R11: the select rises only after a ready report with the oscillator on
    a_r11_rise_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_q) |-> $past(xtal_ready_i && hs_en_i));

endmodule

// File: rtl/pwr_mode_seq.sv
// Power mode sequencer top. Holds the reached mode and the transition target,
// and joins the request decoder, the settle timer, the domain map and the clock switch.
// Assumes: all inputs are synchronous to clk, and each delay parameter is >= 1 cycle.
module pwr_mode_seq
    import pwr_seq_pkg::*;
#(
    parameter int unsigned D_RST_NOLS   = 1500,
    parameter int unsigned D_RST_RING   = 7000,
    parameter int unsigned D_RST_XTAL   = 94000,
    parameter int unsigned D_SBY_NOLS   = 420,
    parameter int unsigned D_SBY_RING   = 6200,
    parameter int unsigned D_SBY_XTAL   = 93000,
    parameter int unsigned D_SLP_WAKE   = 420,
    parameter int unsigned D_RX_CHG     = 125,
    parameter int unsigned D_RX_SAME    = 61,
    parameter int unsigned D_TX_CHG     = 131,
    parameter int unsigned D_TX_SAME    = 67,
    parameter int unsigned D_RADIO_SWAP = 150,
    parameter int unsigned D_ENTER_LOW  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_reset_i,
    input  logic             wake_timer_i,
    input  logic             spi_wake_i,
    input  logic             req_standby_i,
    input  logic             req_sleep_i,
    input  logic             req_rx_i,
    input  logic             req_tx_i,
    input  logic             req_active_i,
    input  logic             chan_change_i,
    input  logic [1:0]       ls_src_i,
    input  logic             ram_off_i,
    input  logic             xtal_ready_i,
    output logic [2:0]       mode_o,
    output logic             busy_o,
    output logic [DOM_N-1:0] dom_en_o,
    output logic             clk_xtal_o
);

    localparam int unsigned MAX_A = umax(umax(D_RST_NOLS, D_RST_RING), umax(D_RST_XTAL, D_SBY_NOLS));
    localparam int unsigned MAX_B = umax(umax(D_SBY_RING, D_SBY_XTAL), umax(D_SLP_WAKE, D_RX_CHG));
    localparam int unsigned MAX_C = umax(umax(D_RX_SAME, D_TX_CHG), umax(D_TX_SAME, D_RADIO_SWAP));
    localparam int unsigned MAX_D = umax(umax(MAX_A, MAX_B), umax(MAX_C, D_ENTER_LOW));
    localparam int          CNT_W = $clog2(MAX_D + 1);

    pm_mode_e         mode_q;
    pm_mode_e         tgt_q;
    pm_mode_e         dec_tgt;
    pm_mode_e         en_mode;
    logic             dec_start;
    logic [CNT_W-1:0] dec_len;
    logic             running;
    logic             done;
    logic             idle;

    // A new transition may start only when none is open and reset is released
    assign idle = !running && !ext_reset_i;

    pms_req_decode #(
        .D_RST_NOLS   (D_RST_NOLS),
        .D_RST_RING   (D_RST_RING),
        .D_RST_XTAL   (D_RST_XTAL),
        .D_SBY_NOLS   (D_SBY_NOLS),
        .D_SBY_RING   (D_SBY_RING),
        .D_SBY_XTAL   (D_SBY_XTAL),
        .D_SLP_WAKE   (D_SLP_WAKE),
        .D_RX_CHG     (D_RX_CHG),
        .D_RX_SAME    (D_RX_SAME),
        .D_TX_CHG     (D_TX_CHG),
        .D_TX_SAME    (D_TX_SAME),
        .D_RADIO_SWAP (D_RADIO_SWAP),
        .D_ENTER_LOW  (D_ENTER_LOW),
        .CNT_W        (CNT_W)
    ) decode_i (
        .mode_i        (mode_q),
        .idle_i        (idle),
        .wake_timer_i  (wake_timer_i),
        .spi_wake_i    (spi_wake_i),
        .req_standby_i (req_standby_i),
        .req_sleep_i   (req_sleep_i),
        .req_rx_i      (req_rx_i),
        .req_tx_i      (req_tx_i),
        .req_active_i  (req_active_i),
        .chan_change_i (chan_change_i),
        .ls_src_i      (ls_src_i),
        .start_o       (dec_start),
        .tgt_o         (dec_tgt),
        .len_o         (dec_len)
    );

    pms_settle_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort_i   (ext_reset_i),
        .start_i   (dec_start),
        .len_i     (dec_len),
        .running_o (running),
        .done_o    (done)
    );

    // Record the target when a transition opens; commit it as the mode when it closes
    always_ff @(posedge clk) begin
        if (!rst_n || ext_reset_i) begin
            mode_q <= PM_RESET;
            tgt_q  <= PM_RESET;
        end else if (dec_start) begin
            tgt_q  <= dec_tgt;
        end else if (done) begin
            mode_q <= tgt_q;
        end
    end

    // Enables follow the target for the whole transition
    assign en_mode = running ? tgt_q : mode_q;

    pms_domain_map map_i (
        .mode_i    (en_mode),
        .ram_off_i (ram_off_i),
        .en_o      (dom_en_o)
    );

    pms_clk_switch clksw_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .hs_en_i      (dom_en_o[DOM_HSO]),
        .xtal_ready_i (xtal_ready_i),
        .use_xtal_o   (clk_xtal_o)
    );

    assign mode_o = mode_q;
    assign busy_o = running;

    // R1: external reset clears mode, busy and every enable on the next edge
    a_r1_ext_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ext_reset_i |=> (mode_o == PM_RESET && !busy_o && dom_en_o == '0));

    // R3: the regulator stays on in every reached mode except Reset
    a_r3_regulator_on: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != PM_RESET) |-> dom_en_o[DOM_REG]);

    // R4: the two radio chains never run together
    a_r4_chains_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dom_en_o[DOM_RXC] && dom_en_o[DOM_TXC]));

    // R8: the reported mode moves forward only on the edge that ends a transition
    a_r8_mode_on_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mode_o) && mode_o != PM_RESET) |-> ($past(busy_o) && !busy_o));

    // R8: the target does not move while a transition is open
    a_r8_target_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ext_reset_i) |=> $stable(tgt_q));

    // R7: Standby without a serial wake stays put
    a_r7_standby_needs_spi: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == PM_STANDBY && !busy_o && !ext_reset_i && !spi_wake_i) |=> !busy_o);

    // R6: Sleep with either wake source starts powering the core
    a_r6_sleep_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == PM_SLEEP && !busy_o && !ext_reset_i && (wake_timer_i || spi_wake_i))
        |=> (busy_o && dom_en_o[DOM_CORE]));

endmodule

// File: tb/pwr_mode_seq_tb_top.sv
// Bench for the power mode sequencer. A behavioural model steps with the clock and
// is compared with the outputs every cycle. Directed scenarios then check durations,
// priority and options.
module pwr_mode_seq_tb_top;

    localparam int T_RST_NOLS = 20, T_RST_RING = 35, T_RST_XTAL = 50;
    localparam int T_SBY_NOLS = 6,  T_SBY_RING = 11, T_SBY_XTAL = 17;
    localparam int T_SLP = 9, T_RX_CHG = 13, T_RX_SAME = 7, T_TX_CHG = 14, T_TX_SAME = 8;
    localparam int T_SWAP = 16, T_LOW = 3;
    localparam int WD_LIMIT = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_reset = 1'b1;
    logic tmr = 0, spi = 0, r_sb = 0, r_sl = 0, r_rx = 0, r_tx = 0, r_ac = 0, chg = 0;
    logic [1:0] ls = 2'b00;
    logic ram_off = 0, rdy = 0;
    logic [2:0] mode_o;
    logic       busy_o;
    logic [8:0] dom_en_o;
    logic       clk_xtal_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pwr_mode_seq #(
        .D_RST_NOLS(T_RST_NOLS), .D_RST_RING(T_RST_RING), .D_RST_XTAL(T_RST_XTAL),
        .D_SBY_NOLS(T_SBY_NOLS), .D_SBY_RING(T_SBY_RING), .D_SBY_XTAL(T_SBY_XTAL),
        .D_SLP_WAKE(T_SLP), .D_RX_CHG(T_RX_CHG), .D_RX_SAME(T_RX_SAME),
        .D_TX_CHG(T_TX_CHG), .D_TX_SAME(T_TX_SAME), .D_RADIO_SWAP(T_SWAP),
        .D_ENTER_LOW(T_LOW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_reset_i(ext_reset), .wake_timer_i(tmr),
        .spi_wake_i(spi), .req_standby_i(r_sb), .req_sleep_i(r_sl), .req_rx_i(r_rx),
        .req_tx_i(r_tx), .req_active_i(r_ac), .chan_change_i(chg), .ls_src_i(ls),
        .ram_off_i(ram_off), .xtal_ready_i(rdy), .mode_o(mode_o), .busy_o(busy_o),
        .dom_en_o(dom_en_o), .clk_xtal_o(clk_xtal_o)
    );

    // Enable set per mode as listed in R3, with the R10 option
    function automatic logic [8:0] exp_en(input int m, input bit roff);
        logic [8:0] e;
        e = '0;
        case (m)
            1: e = 9'b1_0000_0011;
            2: e = 9'b1_0000_0111;
            3: e = 9'b1_0001_1111;
            4: e = 9'b1_0111_1111;
            5: e = 9'b1_1011_1111;
            default: e = '0;
        endcase
        if ((m == 1 || m == 2) && roff) e[8] = 1'b0;
        return e;
    endfunction

    // Model state
    int  m_mode = 0, m_tgt = 0, m_left = 0;
    bit  m_busy = 0, m_sel = 0;

    // Model step, on the same edge as the design
    always @(posedge clk) begin
        logic [8:0] e_old;
        bit go;
        int t, d;
        e_old = exp_en(m_busy ? m_tgt : m_mode, ram_off);
        if (!rst_n) m_sel = 0;
        else if (!e_old[3]) m_sel = 0;
        else if (rdy) m_sel = 1;
        if (!rst_n || ext_reset) begin
            m_mode = 0; m_tgt = 0; m_busy = 0; m_left = 0;
        end else if (!m_busy) begin
            go = 0; t = 0; d = 0;
            case (m_mode)
                0: begin go = 1; t = 3; d = (ls == 0) ? T_RST_NOLS : (ls == 1) ? T_RST_RING : T_RST_XTAL; end
                1: if (spi) begin go = 1; t = 3; d = (ls == 0) ? T_SBY_NOLS : (ls == 1) ? T_SBY_RING : T_SBY_XTAL; end
                2: if (tmr || spi) begin go = 1; t = 3; d = T_SLP; end
                3: if (r_sb) begin go = 1; t = 1; d = T_LOW; end
                   else if (r_sl) begin go = 1; t = 2; d = T_LOW; end
                   else if (r_rx) begin go = 1; t = 4; d = chg ? T_RX_CHG : T_RX_SAME; end
                   else if (r_tx) begin go = 1; t = 5; d = chg ? T_TX_CHG : T_TX_SAME; end
                4: if (r_tx) begin go = 1; t = 5; d = T_SWAP; end
                   else if (r_ac) begin go = 1; t = 3; d = T_LOW; end
                5: if (r_rx) begin go = 1; t = 4; d = T_SWAP; end
                   else if (r_ac) begin go = 1; t = 3; d = T_LOW; end
                default: ;
            endcase
            if (go) begin m_busy = 1; m_tgt = t; m_left = d; end
        end else begin
            m_left = m_left - 1;
            if (m_left == 0) begin m_mode = m_tgt; m_busy = 0; end
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check_eq("R8 mode", int'(mode_o), m_mode);
            check_eq("R8 busy", int'(busy_o), int'(m_busy));
            check_eq("R3 enables", int'(dom_en_o), int'(exp_en(m_busy ? m_tgt : m_mode, ram_off)));
            check_eq("R11 clock select", int'(clk_xtal_o), int'(m_sel));
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !finished) begin
            total++; bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Hold the given requests for one sampling edge, then clear them
    task automatic pulse(input bit sb, input bit sl, input bit rx, input bit tx,
                         input bit ac, input bit tm, input bit sp);
        step();
        r_sb = sb; r_sl = sl; r_rx = rx; r_tx = tx; r_ac = ac; tmr = tm; spi = sp;
        step();
        r_sb = 0; r_sl = 0; r_rx = 0; r_tx = 0; r_ac = 0; tmr = 0; spi = 0;
    endtask

    // Count busy cycles from the starting edge, then check duration and final mode
    task automatic timed(input string tag, input int exp_d, input int exp_mode);
        int n = 0;
        @(negedge clk);
        while (busy_o && n < 100000) begin
            n++;
            @(negedge clk);
        end
        check_eq({tag, " duration"}, n, exp_d);
        check_eq({tag, " mode"}, int'(mode_o), exp_mode);
    endtask

    initial begin
        repeat (4) step();
        rst_n = 1;
        repeat (3) step();
        @(negedge clk);
        check_eq("R1 reset mode", int'(mode_o), 0);
        check_eq("R1 reset enables", int'(dom_en_o), 0);
        check_eq("R1 reset busy", int'(busy_o), 0);

        // R2: wake-up from Reset with no low-speed clock
        step(); ext_reset = 0; step();
        timed("R2 reset->active none", T_RST_NOLS, 3);

        // R11: crystal select follows ready
        @(negedge clk);
        check_eq("R11 select before ready", int'(clk_xtal_o), 0);
        step(); rdy = 1; step();
        @(negedge clk);
        check_eq("R11 select after ready", int'(clk_xtal_o), 1);

        // R5: radio entry lengths
        chg = 1; pulse(0, 0, 1, 0, 0, 0, 0); timed("R5 active->rx change", T_RX_CHG, 4);
        pulse(0, 0, 0, 1, 0, 0, 0);          timed("R4 rx->tx swap", T_SWAP, 5);
        pulse(0, 0, 1, 0, 0, 0, 0);          timed("R4 tx->rx swap", T_SWAP, 4);
        pulse(0, 0, 0, 0, 1, 0, 0);          timed("R9 rx->active", T_LOW, 3);
        chg = 0; pulse(0, 0, 0, 1, 0, 0, 0);
        @(negedge clk);
        check_eq("R12 tx set at start", int'(dom_en_o), int'(exp_en(5, 0)));
        check_eq("R12 old mode kept", int'(mode_o), 3);
        while (busy_o) @(negedge clk);
        check_eq("R5 active->tx same mode", int'(mode_o), 5);
        pulse(0, 0, 0, 0, 1, 0, 0);          timed("R9 tx->active", T_LOW, 3);
        pulse(0, 0, 1, 0, 0, 0, 0);          timed("R5 active->rx same", T_RX_SAME, 4);
        pulse(0, 0, 0, 0, 1, 0, 0);          timed("R9 rx->active again", T_LOW, 3);
        chg = 1; pulse(0, 0, 0, 1, 0, 0, 0); timed("R5 active->tx change", T_TX_CHG, 5);
        pulse(0, 1, 1, 0, 1, 0, 0);          timed("R9 tx: rx outranks active", T_SWAP, 4);
        pulse(0, 0, 0, 0, 1, 0, 0);          timed("R9 back to active", T_LOW, 3);

        // R8: requests during a transition are dropped
        chg = 0; pulse(0, 0, 1, 0, 0, 0, 0);
        repeat (2) step();
        r_tx = 1; r_ac = 1; r_sb = 1; step(); r_tx = 0; r_ac = 0; r_sb = 0;
        while (busy_o) @(negedge clk);
        check_eq("R8 ignored request target", int'(mode_o), 4);
        repeat (4) step();
        @(negedge clk);
        check_eq("R8 nothing queued busy", int'(busy_o), 0);
        check_eq("R8 nothing queued mode", int'(mode_o), 4);
        pulse(0, 0, 0, 0, 1, 0, 0);          timed("R9 rx->active 3", T_LOW, 3);

        // R9 / R7: standby wins, then only the serial wake exits
        ram_off = 1;
        pulse(1, 1, 1, 1, 0, 0, 0);          timed("R9 standby first", T_LOW, 1);
        check_eq("R10 standby ram bank off", int'(dom_en_o[8]), 0);
        pulse(0, 1, 1, 1, 1, 1, 0);
        repeat (2) @(negedge clk);
        check_eq("R7 standby ignores timer", int'(busy_o), 0);
        check_eq("R7 standby mode kept", int'(mode_o), 1);
        ls = 2'b01; pulse(0, 0, 0, 0, 0, 0, 1); timed("R7 standby->active ring", T_SBY_RING, 3);
        check_eq("R10 active ram bank on", int'(dom_en_o[8]), 1);

        // R6: Sleep exits on either source
        pulse(0, 1, 1, 1, 0, 0, 0);          timed("R9 sleep over radio", T_LOW, 2);
        check_eq("R10 sleep ram bank off", int'(dom_en_o[8]), 0);
        pulse(0, 0, 0, 0, 0, 1, 0);          timed("R6 sleep timer wake", T_SLP, 3);
        ram_off = 0;
        pulse(0, 1, 0, 0, 0, 0, 0);          timed("R9 sleep again", T_LOW, 2);
        check_eq("R10 sleep ram bank kept", int'(dom_en_o[8]), 1);
        pulse(0, 0, 0, 0, 0, 0, 1);          timed("R6 sleep spi wake", T_SLP, 3);

        // R7 with no low-speed clock and with a crystal
        ls = 2'b00; pulse(1, 0, 0, 0, 0, 0, 0); timed("R9 standby entry", T_LOW, 1);
        pulse(0, 0, 0, 0, 0, 0, 1);          timed("R7 standby->active none", T_SBY_NOLS, 3);
        ls = 2'b10; pulse(1, 0, 0, 0, 0, 0, 0); timed("R9 standby entry 2", T_LOW, 1);
        pulse(0, 0, 0, 0, 0, 0, 1);          timed("R7 standby->active xtal", T_SBY_XTAL, 3);

        // R1: external reset aborts a transition in progress
        pulse(0, 0, 1, 0, 0, 0, 0);
        repeat (3) step();
        ext_reset = 1;
        repeat (2) step();
        @(negedge clk);
        check_eq("R1 abort mode", int'(mode_o), 0);
        check_eq("R1 abort busy", int'(busy_o), 0);
        check_eq("R1 abort enables", int'(dom_en_o), 0);
        step(); ext_reset = 0; step();
        timed("R2 reset->active xtal", T_RST_XTAL, 3);
        step(); ext_reset = 1; ls = 2'b11; step(); step(); ext_reset = 0; step();
        timed("R2 reset->active src 11", T_RST_XTAL, 3);
        step(); ext_reset = 1; ls = 2'b01; step(); step(); ext_reset = 0; step();
        timed("R2 reset->active ring", T_RST_RING, 3);

        repeat (3) step();
        finish_run();
    end

endmodule